// File: doc/BRIEF.md
# Per-Bank Write Status Reporter

This block sits on the read-data path of a flash memory that is split into several banks, any one of which may be running an internal program or erase while the others stay readable. On each read the host names a bank. If that bank is idle, the word coming from the array goes out unchanged. If that bank is busy, the array contents are not usable, so the block returns a status word instead. That word is built from the last word written into the busy bank. The polling bit is inverted while the cycle runs, and a toggle bit changes value on every read of that bank.

The busy flags come from the bank write sequencer. A flag rises when the write strobe that launches the internal cycle completes, and it falls when the cycle ends. An internal cycle cannot be aborted. The sequencer drops the flag only when the cycle is done, which for a large erase can be tens of milliseconds. Each bank has its own toggle state. That state is held at zero while the bank is idle, so every new internal cycle starts its toggle sequence from zero. The read output is combinational from the current inputs and the toggle registers. The toggle registers advance on the clock edge that ends a read cycle.

Top module: `flash_status_top`

## Requirements
- R1: A read (`rdStrobe`=1) of a bank whose `bankBusy` bit is 0 returns `arrayData` on `rdData` in every bit. This includes the first cycle after that bank's busy flag falls, which is the completion handoff.
- R2: A read of a busy bank returns bit 7 of `rdData` as the inverse of bit 7 of that bank's `lastWord` slice. The slice for bank b is `lastWord[b*16 +: 16]`.
- R3: A read of a busy bank returns every bit of `rdData` other than bits 7 and 6 equal to the matching bit of that bank's `lastWord` slice.
- R4: The first read of a bank after its busy flag rises returns bit 6 as 0.
- R5: Each read of a busy bank inverts the bit 6 value that the next read of that bank will return. Cycles without a read of that bank leave it unchanged, including reads of other banks.
- R6: The toggle state of each bank is independent. Reads of one busy bank never change the bit 6 returned for another busy bank.
- R7: A bank whose busy flag has fallen and then risen again starts its bit 6 sequence at 0. A read in a cycle where the flag is 0 returns array data.
- R8: After reset, the first read of any bank that has just become busy returns bit 6 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankBusy | input | NUM_BANKS | One flag per bank, high while that bank runs an internal program or erase |
| lastWord | input | NUM_BANKS*DATA_W | Last word loaded into each bank, bank b in slice b*DATA_W |
| arrayData | input | DATA_W | Word read from the array for the addressed bank |
| rdStrobe | input | 1 | Read cycle in progress this clock |
| rdBank | input | BANK_W | Bank addressed by the read |
| rdData | output | DATA_W | Word returned to the host |

## Verification
On every clock, the embedded assertions check three things for any read. A read of an idle bank passes array data through. A read of a busy bank carries the inverted polling bit and the untouched low and high fields. The per-bank toggle register flips after a busy read, holds otherwise, and sits at zero while its bank is idle. Other properties only show up over whole sequences, and only the bench scenarios can demonstrate them. These are the 0,1,0 pattern seen over successive reads, the independence between two banks busy at the same time, the restart from zero when a bank begins a new cycle, and the clean handoff to array data on the completion clock.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic showStatus;  // current read targets a busy bank
    logic toggleOut;   // toggle value to present on this read
  } statusCtrl_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  logic                 rdStrobe,
  input  logic [BANK_W-1:0]    rdBank,
  output statusCtrl_t          ctrl
);

  logic [NUM_BANKS-1:0] togReg;
  logic [NUM_BANKS-1:0] bankHit;

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : gBank
      assign bankHit[g] = rdStrobe && (rdBank == BANK_W'(g));

      // Toggle parks at zero while idle, flips on each read while busy
      always_ff @(posedge clk) begin
        if (!rstN)               togReg[g] <= 1'b0;
        else if (!bankBusy[g])   togReg[g] <= 1'b0;
        else if (bankHit[g])     togReg[g] <= ~togReg[g];
      end

      assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
        (bankHit[g] && bankBusy[g]) |=> (togReg[g] != $past(togReg[g])));

      assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!bankHit[g] && bankBusy[g]) |=> $stable(togReg[g]));

      assert_toggle_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
        (!bankBusy[g]) |=> (togReg[g] == 1'b0));
    end
  endgenerate

  logic selBusy;
  logic selTog;

  always_comb begin
    selBusy = 1'b0;
    selTog  = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rdBank == BANK_W'(i)) begin
        selBusy = bankBusy[i];
        selTog  = togReg[i];
      end
    end
    ctrl.showStatus = rdStrobe && selBusy;
    ctrl.toggleOut  = selTog;
  end

endmodule

// File: rtl/flash_status_data.sv
module flash_status_data
  import flash_status_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int DATA_W     = 16,
  parameter int BANK_W     = 2,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  statusCtrl_t                 ctrl,
  input  logic [NUM_BANKS*DATA_W-1:0] lastWord,
  input  logic [DATA_W-1:0]           arrayData,
  input  logic [BANK_W-1:0]           rdBank,
  output logic [DATA_W-1:0]           rdData
);

  logic [DATA_W-1:0] selWord;
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rdBank == BANK_W'(i)) selWord = lastWord[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    statusWord             = selWord;
    statusWord[POLL_BIT]   = ~selWord[POLL_BIT];
    statusWord[TOGGLE_BIT] = ctrl.toggleOut;
  end

  assign rdData = ctrl.showStatus ? statusWord : arrayData;

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top
  import flash_status_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int DATA_W     = 16,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS-1:0]        bankBusy,
  input  logic [NUM_BANKS*DATA_W-1:0] lastWord,
  input  logic [DATA_W-1:0]           arrayData,
  input  logic                        rdStrobe,
  input  logic [BANK_W-1:0]           rdBank,
  output logic [DATA_W-1:0]           rdData
);

  statusCtrl_t ctrl;

  flash_status_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bankBusy(bankBusy),
    .rdStrobe(rdStrobe),
    .rdBank  (rdBank),
    .ctrl    (ctrl)
  );

  flash_status_data #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .BANK_W    (BANK_W),
    .POLL_BIT  (POLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) i_data (
    .ctrl     (ctrl),
    .lastWord (lastWord),
    .arrayData(arrayData),
    .rdBank   (rdBank),
    .rdData   (rdData)
  );

  // Port-level checks on the returned word
  logic bankIsBusy;
  logic [DATA_W-1:0] addrWord;
  logic [DATA_W-1:0] fieldMask;

  always_comb begin
    bankIsBusy = 1'b0;
    addrWord   = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rdBank == BANK_W'(i)) begin
        bankIsBusy = bankBusy[i];
        addrWord   = lastWord[i*DATA_W +: DATA_W];
      end
    end
    fieldMask             = '1;
    fieldMask[POLL_BIT]   = 1'b0;
    fieldMask[TOGGLE_BIT] = 1'b0;
  end

  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !bankIsBusy) |-> (rdData == arrayData));

  assert_poll_inv_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && bankIsBusy) |-> (rdData[POLL_BIT] != addrWord[POLL_BIT]));

  assert_other_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && bankIsBusy) |-> ((rdData & fieldMask) == (addrWord & fieldMask)));

endmodule

// File: tb/test_flash_status_top.sv
module test_flash_status_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NB-1:0] bankBusy;
  logic [NB*DW-1:0] lastWord;
  logic [DW-1:0] arrayData;
  logic          rdStrobe;
  logic [1:0]    rdBank;
  logic [DW-1:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [NB-1:0] mTog;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_top i_flash_status_top (
    .clk(clk), .rstN(rstN), .bankBusy(bankBusy), .lastWord(lastWord),
    .arrayData(arrayData), .rdStrobe(rdStrobe), .rdBank(rdBank), .rdData(rdData)
  );

  function automatic logic [DW-1:0] expWord(input logic [1:0] b);
    logic [DW-1:0] w;
    if (!bankBusy[b]) return arrayData;
    w = lastWord[b*DW +: DW];
    w[7] = ~w[7];
    w[6] = mTog[b];
    return w;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check shortly after, then advance the model to the next edge
  task automatic cycle(input logic strobe, input logic [1:0] b, input string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    rdStrobe  = strobe;
    rdBank    = b;
    arrayData = DW'($urandom);
    #1;
    if (strobe) begin
      e = expWord(b);
      if (bankBusy[b]) begin
        check({tag, " R2 poll"}, {15'd0, rdData[7]}, {15'd0, e[7]});
        check({tag, " R3 fields"}, rdData & 16'hFF3F, e & 16'hFF3F);
        check({tag, " R5 toggle"}, {15'd0, rdData[6]}, {15'd0, e[6]});
      end else begin
        check({tag, " R1 pass"}, rdData, e);
      end
    end
    for (int k = 0; k < NB; k++) begin
      if (!bankBusy[k]) mTog[k] = 1'b0;
      else if (strobe && b == 2'(k)) mTog[k] = ~mTog[k];
    end
  endtask

  task automatic setBusy(input logic [NB-1:0] v);
    @(negedge clk);
    bankBusy = v;
    rdStrobe = 1'b0;
    for (int k = 0; k < NB; k++) if (!v[k]) mTog[k] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; bankBusy = '0; rdStrobe = 1'b0; rdBank = '0;
    arrayData = '0; mTog = '0;
    lastWord = {16'hA5F0, 16'h1234, 16'h00FF, 16'hC3C3};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: first busy read after reset shows toggle 0
    setBusy(4'b0001);
    cycle(1'b1, 2'd0, "R8");
    testsRun++;
    if (rdData[6] !== 1'b0) begin
      testsFailed++;
      $display("FAIL R8: actual %b expected 0", rdData[6]);
    end

    // R4/R5: successive reads of bank 1, 0 1 0, with idle-bank reads between
    setBusy(4'b0010);
    cycle(1'b1, 2'd1, "R4");
    cycle(1'b1, 2'd2, "R1");
    cycle(1'b0, 2'd1, "R5 gap");
    cycle(1'b1, 2'd1, "R5");
    cycle(1'b1, 2'd1, "R5");

    // R6: two banks busy together keep separate toggles
    setBusy(4'b1010);
    cycle(1'b1, 2'd3, "R6");
    cycle(1'b1, 2'd3, "R6");
    cycle(1'b1, 2'd1, "R6");
    cycle(1'b1, 2'd3, "R6");

    // R7: completion handoff then restart from zero
    setBusy(4'b1000);
    cycle(1'b1, 2'd1, "R7 handoff");
    setBusy(4'b1010);
    cycle(1'b1, 2'd1, "R7 restart");
    testsRun++;
    if (rdData[6] !== 1'b0) begin
      testsFailed++;
      $display("FAIL R7: actual %b expected 0", rdData[6]);
    end

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) setBusy(NB'($urandom));
      if ($urandom_range(0, 31) == 0) lastWord = {$urandom, $urandom};
      cycle($urandom_range(0, 3) != 0, 2'($urandom), "RND");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule